// File: doc/BRIEF.md
# Daisy-Chained Interrupt Requester

Per-card interrupt logic for a chained interrupt line that carries one-word vectored interrupts. A local source event arms the card. The card then raises its request on the outgoing chain line, in step with the strobe that marks the trailing edge of clock phase 3 of the memory cycle. When the acknowledge pulse arrives, the card drops its request at once. It drives a fixed one-byte instruction onto the data bus for as long as the acknowledge stays high. The byte is a parameter and is normally a restart opcode.

A card that is configured with interrupts off becomes a plain wire from the incoming chain line to the outgoing one. It never drives the data bus. The card holds at most one request at a time. Source events that arrive while a request is armed, pending or being served are absorbed. A fresh request needs a new rising edge of the source after the acknowledge has ended.

Top module: `irq_chain_requester`

## Requirements
- R1: While reset is held, `int_out_o` equals `int_in_i`, `data_oe_o` is 0 and `data_o` is 8'h00.
- R2: A rising edge on `src_i` arms the card, and the request appears on `int_out_o` only after a later clock edge at which `phi3_fall_i` is 1. A strobe in the same cycle as the source edge does not raise the request.
- R3: A `phi3_fall_i` strobe with no armed event leaves `int_out_o` low.
- R4: While enabled, `int_out_o` is the OR of `int_in_i` and this card's own pending request.
- R5: Once `ack_i` is 1, the card's own contribution to `int_out_o` is 0 in that same cycle. The request is cleared at the next clock edge.
- R6: While `ack_i` stays 1 after it found this card pending, `data_oe_o` is 1 and `data_o` equals INSTR (default 8'hC7). In every other cycle `data_o` is 8'h00 and `data_oe_o` is 0.
- R7: An acknowledge that arrives while the card has no pending request does not enable the data bus.
- R8: A source edge that arrives while the card is armed, pending or being served adds no second request. A source held high across the end of the acknowledge does not retrigger.
- R9: With `en_i` at 0, `int_out_o` follows `int_in_i`, `data_oe_o` is 0, and any armed or pending request is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | 1: card uses interrupts; 0: pass-through |
| src_i | input | 1 | Local interrupt source, rising edge is an event |
| phi3_fall_i | input | 1 | One-cycle strobe at trailing edge of clock phase 3 |
| int_in_i | input | 1 | Incoming chain interrupt line |
| ack_i | input | 1 | Interrupt acknowledge pulse |
| int_out_o | output | 1 | Outgoing chain interrupt line |
| data_o | output | DATA_W | Instruction byte, zero when not driving |
| data_oe_o | output | 1 | Data bus drive enable |

## Verification
The bench tests that the request waits for the phase-3 strobe. A design that raised the line on the source edge, or on a strobe in the same cycle as that edge, would fail. It piles extra source edges onto the armed, pending and serving states, and holds the source high across the end of the acknowledge. A design that counted events twice or worked on level rather than edge would raise a second request. It sends acknowledges that do not belong to this card, and drops the enable while a request is pending. A design that drove the bus without a pending request, or kept a stale request after being disabled, would show up as a wrong enable or a wrong line state.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_PEND  = 2'd2,
    ST_SERVE = 2'd3
  } req_state_e;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) d_q <= 1'b0;
    else         d_q <= d_i;
  end

  assign rise_o = d_i & ~d_q;
endmodule

// File: rtl/irq_req_fsm.sv
module irq_req_fsm
  import irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       rise_i,
  input  logic       strobe_i,
  input  logic       ack_i,
  output req_state_e st_o
);
  req_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!en_i) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE:  if (rise_i)   st_d = ST_ARMED;
        ST_ARMED: if (strobe_i) st_d = ST_PEND;
        ST_PEND:  if (ack_i)    st_d = ST_SERVE;
        ST_SERVE: if (!ack_i)   st_d = ST_IDLE;
        default:                st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign st_o = st_q;
endmodule

// File: rtl/irq_bus_drive.sv
module irq_bus_drive
  import irq_pkg::*;
#(
  parameter int unsigned       DATA_W = 8,
  parameter logic [DATA_W-1:0] INSTR  = 8'hC7
) (
  input  logic              en_i,
  input  req_state_e        st_i,
  input  logic              ack_i,
  input  logic              int_in_i,
  output logic              int_out_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  logic own_line;
  logic owned;

  // ack masks own request immediately, before state update
  assign own_line  = (st_i == ST_PEND) & ~ack_i;
  assign owned     = (st_i == ST_PEND) | (st_i == ST_SERVE);
  assign int_out_o = en_i ? (int_in_i | own_line) : int_in_i;
  assign data_oe_o = en_i & ack_i & owned;
  assign data_o    = data_oe_o ? INSTR : '0;
endmodule

// File: rtl/irq_chain_requester.sv
module irq_chain_requester
  import irq_pkg::*;
#(
  parameter int unsigned       DATA_W = 8,
  parameter logic [DATA_W-1:0] INSTR  = 8'hC7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              src_i,
  input  logic              phi3_fall_i,
  input  logic              int_in_i,
  input  logic              ack_i,
  output logic              int_out_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  logic       src_rise;
  req_state_e st_q;

  irq_edge_detect u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (src_i),
    .rise_o (src_rise)
  );

  irq_req_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .rise_i   (src_rise),
    .strobe_i (phi3_fall_i),
    .ack_i    (ack_i),
    .st_o     (st_q)
  );

  irq_bus_drive #(.DATA_W(DATA_W), .INSTR(INSTR)) u_drive (
    .en_i      (en_i),
    .st_i      (st_q),
    .ack_i     (ack_i),
    .int_in_i  (int_in_i),
    .int_out_o (int_out_o),
    .data_o    (data_o),
    .data_oe_o (data_oe_o)
  );
endmodule

// File: rtl/irq_chain_requester_chk.sv
module irq_chain_requester_chk
  import irq_pkg::*;
#(
  parameter int unsigned       DATA_W = 8,
  parameter logic [DATA_W-1:0] INSTR  = 8'hC7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              phi3_fall_i,
  input logic              int_in_i,
  input logic              ack_i,
  input logic              int_out_o,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o,
  input req_state_e        st_q
);
  p_strobe_raises_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q == ST_PEND) |-> $past(phi3_fall_i));

  p_ack_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ack_i && !int_in_i) |-> !int_out_o);

  p_drive_value_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (ack_i && data_o == INSTR));

  p_idle_bus_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> (data_o == '0));

  p_serve_origin_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q == ST_SERVE) |-> $past(st_q == ST_PEND && ack_i));

  p_passthru_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (int_out_o == int_in_i && !data_oe_o));
endmodule

bind irq_chain_requester irq_chain_requester_chk #(.DATA_W(DATA_W), .INSTR(INSTR)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .phi3_fall_i (phi3_fall_i),
  .int_in_i    (int_in_i),
  .ack_i       (ack_i),
  .int_out_o   (int_out_o),
  .data_o      (data_o),
  .data_oe_o   (data_oe_o),
  .st_q        (st_q)
);

// File: tb/irq_chain_requester_bench.sv
module irq_chain_requester_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 21;

  // {en, src, int_in, phi3, ack, exp_out, exp_oe, exp_data}
  localparam logic [14:0] VEC [NV] = '{
    {5'b10000, 2'b00, 8'h00},  // 0  idle
    {5'b10010, 2'b00, 8'h00},  // 1  R3 strobe, nothing armed
    {5'b11000, 2'b00, 8'h00},  // 2  R2 armed, not raised
    {5'b10000, 2'b00, 8'h00},  // 3  armed
    {5'b11000, 2'b00, 8'h00},  // 4  R8 second edge while armed
    {5'b10010, 2'b10, 8'h00},  // 5  R2 strobe raises
    {5'b10100, 2'b10, 8'h00},  // 6  R4 upstream plus own
    {5'b11000, 2'b10, 8'h00},  // 7  R8 edge while pending
    {5'b10001, 2'b01, 8'hC7},  // 8  R5 R6 ack taken
    {5'b10011, 2'b01, 8'hC7},  // 9  R6 still serving
    {5'b11001, 2'b01, 8'hC7},  // 10 R8 edge while serving
    {5'b11000, 2'b00, 8'h00},  // 11 R6 ack ends, src held
    {5'b11010, 2'b00, 8'h00},  // 12 R8 no retrigger
    {5'b10001, 2'b00, 8'h00},  // 13 R7 foreign ack
    {5'b10101, 2'b10, 8'h00},  // 14 R4 R7 upstream, foreign ack
    {5'b11000, 2'b00, 8'h00},  // 15 armed again
    {5'b10010, 2'b10, 8'h00},  // 16 pending
    {5'b00000, 2'b00, 8'h00},  // 17 R9 disable drops request
    {5'b00101, 2'b10, 8'h00},  // 18 R9 pass-through, no drive
    {5'b01010, 2'b00, 8'h00},  // 19 R9 events ignored
    {5'b10010, 2'b00, 8'h00}   // 20 R9 nothing survived
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en, src, int_in, phi3, ack;
  logic       int_out, data_oe;
  logic [7:0] data;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_chain_requester u_irq_chain_requester (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .en_i        (en),
    .src_i       (src),
    .phi3_fall_i (phi3),
    .int_in_i    (int_in),
    .ack_i       (ack),
    .int_out_o   (int_out),
    .data_o      (data),
    .data_oe_o   (data_oe)
  );

  task automatic chk(input string req, input logic eo, input logic eoe, input logic [7:0] ed);
    checks++;
    if (int_out !== eo || data_oe !== eoe || data !== ed) begin
      errors++;
      $display("FAIL %s: out=%b oe=%b data=%h expected out=%b oe=%b data=%h",
               req, int_out, data_oe, data, eo, eoe, ed);
    end
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b1; src = 1'b0; int_in = 1'b1; phi3 = 1'b0; ack = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 reset", 1'b1, 1'b0, 8'h00);
    int_in = 1'b0;
    @(negedge clk);
    chk("R1 reset low", 1'b0, 1'b0, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {en, src, int_in, phi3, ack} = VEC[i][14:10];
      @(posedge clk);
      #1;
      chk($sformatf("R2-R9 vector %0d", i), VEC[i][9], VEC[i][8], VEC[i][7:0]);
    end

    // R2: source edge and strobe in the same cycle only arm
    @(negedge clk); en = 1'b1; src = 1'b1; phi3 = 1'b1; int_in = 1'b0; ack = 1'b0;
    @(posedge clk); #1;
    chk("R2 same-cycle strobe", 1'b0, 1'b0, 8'h00);
    @(negedge clk); src = 1'b0; phi3 = 1'b1;
    @(posedge clk); #1;
    chk("R2 later strobe", 1'b1, 1'b0, 8'h00);
    // R5: own line drops in the ack cycle itself
    @(negedge clk); phi3 = 1'b0; ack = 1'b1;
    #1;
    chk("R5 immediate drop", 1'b0, 1'b1, 8'hC7);
    @(posedge clk); #1;
    chk("R6 serving", 1'b0, 1'b1, 8'hC7);
    // R6: enable falls with ack
    @(negedge clk); ack = 1'b0;
    #1;
    chk("R6 ack end", 1'b0, 1'b0, 8'h00);
    @(posedge clk); #1;
    chk("R5 cleared", 1'b0, 1'b0, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule